// File: doc/BRIEF.md
# Program Status Register Unit

This block keeps the 32-bit status word of a processor core. The word carries four condition flags (negative, zero, carry, overflow), two interrupt mask bits, an instruction-state bit and a five-bit mode field. The core's execute stage sends the ALU result with its carry and overflow, the shifter's carry-out, a class bit and the set-flags bit of the instruction. When set-flags is 1, the unit rebuilds the flags from those inputs.

Two other paths replace the contents of the word. A status-move port writes the word directly. Privileged code can change every defined field through this port. Code running in the unprivileged mode can change only the flags. A restore strobe loads a complete saved word in one cycle, as an exception return does.

Every change takes effect on the next rising clock edge. The full word and each field are always visible on the outputs.

Top module: `psr_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the word reads 0x000000D3. All flags are 0, both interrupt masks are 1, the state bit is 0 and the mode is 5'b10011.
- R2: A cycle with set_flags, wr_en and restore_en all 0 leaves the whole word unchanged.
- R3: When set_flags is 1 and op_arith is 1, the next word has N equal to alu_res[31] and Z equal to 1 exactly when alu_res is zero. C takes alu_carry and V takes alu_ovf.
- R4: When set_flags is 1 and op_arith is 0, N and Z follow the same rule as in R3. C takes shift_carry and V keeps its previous value. alu_carry and alu_ovf have no effect.
- R5: The field positions are fixed. N is bit 31, Z bit 30, C bit 29 and V bit 28. The normal-interrupt mask is bit 7 and the fast-interrupt mask is bit 6, each disabling its interrupt when 1. The state bit is bit 5, with 1 meaning compressed instructions. The mode is bits 4:0. Each field output equals its bits of the word.
- R6: Bits 27:8 always read 0, whatever a direct write or a restore supplies in those bits.
- R7: When the current mode is 5'b10000 (unprivileged), a direct write changes only bits 31:28. Bits 7:0 keep their values.
- R8: In any other mode, a direct write loads bits 31:28 and 7:0 from wr_data.
- R9: A restore loads wr-independent restore_data into the defined bits in one cycle. It has priority over a direct write and over a flag update in the same cycle.
- R10: A direct write has priority over a flag update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_res | input | 32 | ALU result |
| alu_carry | input | 1 | Carry out of bit 31 of the ALU |
| alu_ovf | input | 1 | Signed overflow from the ALU |
| shift_carry | input | 1 | Carry out of the shifter |
| op_arith | input | 1 | 1 for an arithmetic operation, 0 for a logical one |
| set_flags | input | 1 | Set-flags bit of the instruction |
| wr_en | input | 1 | Direct status write strobe |
| wr_data | input | 32 | Direct write data |
| restore_en | input | 1 | Restore-from-saved-word strobe |
| restore_data | input | 32 | Saved word to restore |
| psr | output | 32 | Full status word |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| irq_mask | output | 1 | Normal-interrupt disable |
| fiq_mask | output | 1 | Fast-interrupt disable |
| cmp_state | output | 1 | Compressed instruction state |
| mode | output | 5 | Processor mode |

## Verification
The arithmetic class is driven with results that are zero, negative and positive, and with carry and overflow set independently. This shows whether each flag follows its own source. The logical class is driven with the ALU carry and overflow set opposite to the shifter carry. That exposes any use of the wrong carry, and any change to V where it should hold. Direct writes are tried in a privileged mode and in the unprivileged mode, and all three update paths are raised together. This separates the write mask from the priority order. A long run of random operations then mixes every path against a cycle-by-cycle model.

// File: rtl/psr_unit.sv
module psr_unit #(
  parameter logic [31:0] RESET_WORD = 32'h0000_00D3,
  parameter logic [4:0]  USER_MODE  = 5'b10000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] alu_res,
  input  logic        alu_carry,
  input  logic        alu_ovf,
  input  logic        shift_carry,
  input  logic        op_arith,
  input  logic        set_flags,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        restore_en,
  input  logic [31:0] restore_data,
  output logic [31:0] psr,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_c,
  output logic        flag_v,
  output logic        irq_mask,
  output logic        fiq_mask,
  output logic        cmp_state,
  output logic [4:0]  mode
);

  localparam logic [31:0] FLAG_BITS = 32'hF000_0000;
  localparam logic [31:0] CTRL_BITS = 32'h0000_00FF;
  localparam logic [31:0] LIVE_BITS = FLAG_BITS | CTRL_BITS;

  logic [31:0] word_q, word_d;
  logic        privileged;
  logic [31:0] wr_mask;
  logic [3:0]  nzcv;

  assign privileged = word_q[4:0] != USER_MODE;
  assign wr_mask    = privileged ? LIVE_BITS : FLAG_BITS;

  assign nzcv = {alu_res[31],
                 alu_res == 32'd0,
                 op_arith ? alu_carry : shift_carry,
                 op_arith ? alu_ovf   : word_q[28]};

  always_comb begin
    word_d = word_q;
    if (restore_en)
      word_d = restore_data & LIVE_BITS;
    else if (wr_en)
      word_d = (word_q & ~wr_mask) | (wr_data & wr_mask);
    else if (set_flags)
      word_d[31:28] = nzcv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= RESET_WORD & LIVE_BITS;
    else        word_q <= word_d;
  end

  assign psr       = word_q;
  assign flag_n    = word_q[31];
  assign flag_z    = word_q[30];
  assign flag_c    = word_q[29];
  assign flag_v    = word_q[28];
  assign irq_mask  = word_q[7];
  assign fiq_mask  = word_q[6];
  assign cmp_state = word_q[5];
  assign mode      = word_q[4:0];

endmodule

// File: rtl/psr_unit_chk.sv
module psr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        alu_carry,
  input logic        alu_ovf,
  input logic        shift_carry,
  input logic        op_arith,
  input logic        set_flags,
  input logic        wr_en,
  input logic        restore_en,
  input logic [31:0] restore_data,
  input logic [31:0] psr,
  input logic        flag_c,
  input logic        flag_v,
  input logic [4:0]  mode
);

  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    psr[27:8] == 20'd0);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_flags && !wr_en && !restore_en) |=> $stable(psr));

  p_user_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !restore_en && mode == 5'b10000) |=> psr[27:0] == $past(psr[27:0]));

  p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |=> psr == ($past(restore_data) & 32'hF000_00FF));

  p_arith_cv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && op_arith && !wr_en && !restore_en) |=>
      (flag_c == $past(alu_carry)) && (flag_v == $past(alu_ovf)));

  p_logic_cv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && !op_arith && !wr_en && !restore_en) |=>
      (flag_c == $past(shift_carry)) && (flag_v == $past(flag_v)));

endmodule

bind psr_unit psr_unit_chk chk_i (.*);

// File: tb/psr_unit_tb_top.sv
`timescale 1ns/1ps
module psr_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] alu_res = '0;
  logic        alu_carry = 1'b0, alu_ovf = 1'b0, shift_carry = 1'b0;
  logic        op_arith = 1'b0, set_flags = 1'b0, wr_en = 1'b0, restore_en = 1'b0;
  logic [31:0] wr_data = '0, restore_data = '0;
  logic [31:0] psr;
  logic        flag_n, flag_z, flag_c, flag_v, irq_mask, fiq_mask, cmp_state;
  logic [4:0]  mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string tag = "R1";
  logic [31:0] model = 32'h0000_00D3;

  always #10 clk = ~clk;

  psr_unit dut_i (.*);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model <= 32'h0000_00D3;
    else if (restore_en) model <= restore_data & 32'hF000_00FF;
    else if (wr_en) begin
      logic [31:0] msk;
      msk = (model[4:0] == 5'b10000) ? 32'hF000_0000 : 32'hF000_00FF;
      model <= (model & ~msk) | (wr_data & msk);
    end else if (set_flags) begin
      logic [31:0] nx;
      nx = model;
      nx[31] = alu_res[31];
      nx[30] = (alu_res == 0);
      nx[29] = op_arith ? alu_carry : shift_carry;
      nx[28] = op_arith ? alu_ovf : model[28];
      model <= nx;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(tag, psr, model);
    chk("R5", {flag_n, flag_z, flag_c, flag_v}, {28'd0, model[31:28]});
    chk("R5", {irq_mask, fiq_mask, cmp_state, mode}, {24'd0, model[7:0]});
  end

  task automatic step(string req, logic sf, logic ar, logic [31:0] res,
                      logic ac, logic ao, logic sc,
                      logic we, logic [31:0] wd, logic re, logic [31:0] rd);
    tag = req;
    set_flags = sf; op_arith = ar; alu_res = res;
    alu_carry = ac; alu_ovf = ao; shift_carry = sc;
    wr_en = we; wr_data = wd; restore_en = re; restore_data = rd;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", psr, 32'h0000_00D3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", psr, 32'h0000_00D3);
    // arithmetic patterns
    step("R3", 1, 1, 32'h0000_0000, 1, 0, 0, 0, 0, 0, 0);
    chk("R3", psr, 32'h6000_00D3);
    step("R3", 1, 1, 32'h8000_0000, 0, 1, 1, 0, 0, 0, 0);
    chk("R3", psr, 32'h9000_00D3);
    step("R3", 1, 1, 32'h0000_0005, 0, 0, 1, 0, 0, 0, 0);
    chk("R3", psr, 32'h0000_00D3);
    step("R3", 1, 1, 32'hFFFF_FFFF, 1, 1, 0, 0, 0, 0, 0);
    chk("R3", psr, 32'hB000_00D3);
    // set_flags low: hold
    step("R2", 0, 1, 32'h0000_0000, 0, 0, 0, 0, 0, 0, 0);
    chk("R2", psr, 32'hB000_00D3);
    // logical: V holds, C from shifter
    step("R4", 1, 0, 32'h0000_0000, 0, 0, 0, 0, 0, 0, 0);
    chk("R4", psr, 32'h5000_00D3);
    step("R4", 1, 0, 32'h8000_0001, 0, 0, 1, 0, 0, 0, 0);
    chk("R4", psr, 32'hB000_00D3);
    // privileged writes
    step("R8", 0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF, 0, 0);
    chk("R6", psr, 32'hF000_00FF);
    step("R8", 0, 0, 0, 0, 0, 0, 1, 32'h0000_0010, 0, 0);
    chk("R8", psr, 32'h0000_0010);
    // unprivileged write touches flags only
    step("R7", 0, 0, 0, 0, 0, 0, 1, 32'hA000_00FF, 0, 0);
    chk("R7", psr, 32'hA000_0010);
    // write beats flag update
    step("R10", 1, 1, 32'h0000_0000, 1, 1, 1, 1, 32'h1000_0000, 0, 0);
    chk("R10", psr, 32'h1000_0010);
    // restore beats both
    step("R9", 1, 1, 32'h0000_0000, 1, 1, 1, 1, 32'hFFFF_FFFF, 1, 32'h5FFF_FF13);
    chk("R9", psr, 32'h5000_0013);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic re;
      re = ($urandom % 16) == 0;
      step("R10", 1'($urandom), 1'($urandom),
           ($urandom % 4 == 0) ? 32'd0 : $urandom,
           1'($urandom), 1'($urandom), 1'($urandom),
           ($urandom % 4) == 0, $urandom, re, $urandom);
    end
    step("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule